// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block keeps a table of memory dependency groups for an out-of-order core's load/store scheduling. A group is a set of memory operations that carry no ordering constraint among themselves. The surrounding scheduler allocates a group, fills it with member instructions, links it to younger groups with either ordering edges or data edges, and then reports when members issue and when they finish. The tracker turns these events into a status for each group, from which the scheduler decides whether the group's members may be picked.

Each slot holds six small counters, two successor bitmasks over the slot table (one for ordering edges, one for data edges) and two remaining-cycle values. An ordering edge is released as soon as the source group has issued all of its members. A data edge first counts as started at that point and is only released when every member of the source has finished. While a group still waits on predecessors whose start is unknown, it counts down the largest remaining-cycle hint among data predecessors that have already started.

All inputs are single-cycle event pulses that carry a slot index. The status outputs are driven from registers, so an event is visible on them one clock after its pulse.

Top module: `dg_tracker`

## Requirements
- R1: After reset no slot is valid, `alloc_slot` is 0, `alloc_gid` is 1 and `table_full` is 0.
- R2: An allocation takes the lowest-numbered free slot and hands out the current group id. Ids start at 1, step by one per grant, and skip 0 on wrap. When all slots are valid, `table_full` is 1 and an allocation request has no effect.
- R3: With P predecessors, S started and F finished, a valid group is waiting when P > S+F, pending when S > 0 and S+F = P, and ready when F = P. A fresh group (P = 0) is ready.
- R4: With M members, X executing and D finished, a valid group is executing when X > 0 and X = M−D, and executed when D = M. A fresh group with no members reads as executed.
- R5: When an issue makes a group executing, each of its ordering successors gains a finished predecessor, and each data successor gains a started predecessor.
- R6: When the last member of a group finishes, each of its data successors moves one predecessor from started to finished.
- R7: An ordering edge from a group that is already executing is dropped. A data edge from an executing group credits the new successor with a started predecessor in the same cycle.
- R8: Adding a member to a group that has any successor is rejected. `add_err` is high during that pulse and the group's counters do not change.
- R9: A group's critical count takes the largest remaining-cycle value of its started data predecessors. That value is the largest `issue_cyc` seen among the source's issued members. The count drops by one per cycle only while the group is waiting and the count is nonzero.
- R10: A group with at least one member that has become executed releases its slot on the next clock. All of its status outputs then read 0, and a later allocation reuses the slot with cleared state.
- R11: An edge whose source equals its destination, whose source or destination slot is not valid, or whose source reads as executed, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate a new group |
| alloc_slot | output | IDX_W | Slot the next allocation will take |
| alloc_gid | output | GID_W | Group id the next allocation will take |
| table_full | output | 1 | No free slot |
| add_vld | input | 1 | Add one member to a group |
| add_slot | input | IDX_W | Slot receiving the member |
| add_err | output | 1 | Member add rejected because the group has successors |
| edge_vld | input | 1 | Add a dependency edge |
| edge_src | input | IDX_W | Older (source) group |
| edge_dst | input | IDX_W | Younger (successor) group |
| edge_data | input | 1 | 1 = data edge, 0 = ordering edge |
| issue_vld | input | 1 | A member of a group issued |
| issue_slot | input | IDX_W | Group of the issued member |
| issue_cyc | input | CYC_W | Remaining cycles of the issued member |
| done_vld | input | 1 | A member of a group finished |
| done_slot | input | IDX_W | Group of the finished member |
| grp_valid | output | NUM_SLOTS | Slot holds a group |
| grp_waiting | output | NUM_SLOTS | Waiting flag per slot |
| grp_pending | output | NUM_SLOTS | Pending flag per slot |
| grp_ready | output | NUM_SLOTS | Ready flag per slot |
| grp_executing | output | NUM_SLOTS | Executing flag per slot |
| grp_executed | output | NUM_SLOTS | Executed flag per slot |
| crit_cycles | output | NUM_SLOTS*CYC_W | Critical count per slot, slot i at bits [i*CYC_W +: CYC_W] |

## Verification
The hardest state to reach is a group that is still waiting while it already holds a started data predecessor. Only in that state does the critical count run down. The stimulus builds it with two predecessors: an ordering edge from a group that has not issued, and a data edge from a group that is already executing. It then idles for a few cycles and reads the count as it falls. It then releases the second predecessor and confirms that the count freezes once the group stops waiting. The same sequence covers the dropped ordering edge and the rejected member add on a group that has successors.

// File: rtl/dg_pkg.sv
package dg_pkg;
  localparam int DG_CNT_W = 5;

  typedef logic [DG_CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t n_pred;
    cnt_t n_start;
    cnt_t n_fin;
    cnt_t n_inst;
    cnt_t n_exec;
    cnt_t n_done;
  } grp_cnt_t;

  function automatic logic [DG_CNT_W:0] f_pred_seen(grp_cnt_t c);
    return {1'b0, c.n_start} + {1'b0, c.n_fin};
  endfunction

  function automatic logic f_waiting(grp_cnt_t c);
    return {1'b0, c.n_pred} > f_pred_seen(c);
  endfunction

  function automatic logic f_pending(grp_cnt_t c);
    return (c.n_start != '0) && (f_pred_seen(c) == {1'b0, c.n_pred});
  endfunction

  function automatic logic f_ready(grp_cnt_t c);
    return c.n_fin == c.n_pred;
  endfunction

  function automatic logic f_executing(grp_cnt_t c);
    return (c.n_exec != '0) && (c.n_exec == (c.n_inst - c.n_done));
  endfunction

  function automatic logic f_executed(grp_cnt_t c);
    return c.n_inst == c.n_done;
  endfunction
endpackage

// File: rtl/dg_slot_alloc.sv
module dg_slot_alloc #(
  parameter int NUM_SLOTS = 16,
  parameter int GID_W     = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_req,
  input  logic [NUM_SLOTS-1:0] slot_valid,
  output logic [IDX_W-1:0]     alloc_slot,
  output logic [GID_W-1:0]     alloc_gid,
  output logic                 table_full,
  output logic [NUM_SLOTS-1:0] grant_1h
);
  logic             found;
  logic [IDX_W-1:0] pick;
  logic [GID_W-1:0] gid_q;
  logic [GID_W-1:0] gid_inc;

  // lowest free slot wins: scan from the top so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!slot_valid[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  assign alloc_slot = pick;
  assign table_full = !found;
  assign alloc_gid  = gid_q;
  assign grant_1h   = (alloc_req && found) ? (NUM_SLOTS'(1) << pick) : '0;
  assign gid_inc    = gid_q + GID_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      gid_q <= GID_W'(1);
    else if (alloc_req && found)
      gid_q <= (gid_inc == '0) ? GID_W'(1) : gid_inc;
  end
endmodule

// File: rtl/dg_group_slot.sv
module dg_group_slot
  import dg_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CYC_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_hit,
  input  logic [NUM_SLOTS-1:0] clr_bits,
  input  logic [NUM_SLOTS-1:0] ord_set,
  input  logic [NUM_SLOTS-1:0] dat_set,
  input  logic                 add_hit,
  input  logic                 pred_hit,
  input  logic                 issue_hit,
  input  logic [CYC_W-1:0]     issue_cyc,
  input  logic                 done_hit,
  input  logic [1:0]           start_up,
  input  logic                 start_dn,
  input  logic [1:0]           fin_up,
  input  logic                 cand_vld,
  input  logic [CYC_W-1:0]     cand_cyc,
  output logic                 valid,
  output logic                 waiting,
  output logic                 pending,
  output logic                 ready,
  output logic                 executing,
  output logic                 executed,
  output logic                 go_exec,
  output logic                 go_done,
  output logic                 has_succ,
  output logic [CYC_W-1:0]     crit,
  output logic [CYC_W-1:0]     crit_mem_nxt,
  output logic [NUM_SLOTS-1:0] ord_mask,
  output logic [NUM_SLOTS-1:0] dat_mask
);
  grp_cnt_t         cnt_q, cnt_d;
  logic [CYC_W-1:0] crit_q, crit_d, crit_dec, cmem_q;
  logic             release_slot;

  always_comb begin
    cnt_d         = cnt_q;
    cnt_d.n_inst  = cnt_q.n_inst + cnt_t'(add_hit);
    cnt_d.n_pred  = cnt_q.n_pred + cnt_t'(pred_hit);
    cnt_d.n_start = cnt_q.n_start + cnt_t'(start_up) - cnt_t'(start_dn);
    cnt_d.n_fin   = cnt_q.n_fin + cnt_t'(fin_up);
    cnt_d.n_exec  = cnt_q.n_exec + cnt_t'(issue_hit) - cnt_t'(done_hit);
    cnt_d.n_done  = cnt_q.n_done + cnt_t'(done_hit);
  end

  assign go_exec = f_executing(cnt_d) && !f_executing(cnt_q);
  assign go_done = f_executed(cnt_d) && !f_executed(cnt_q);

  assign crit_dec = (f_waiting(cnt_q) && crit_q != '0) ? crit_q - CYC_W'(1) : crit_q;
  assign crit_d   = (cand_vld && cand_cyc > crit_dec) ? cand_cyc : crit_dec;
  assign crit_mem_nxt = (issue_hit && issue_cyc > cmem_q) ? issue_cyc : cmem_q;

  assign release_slot = valid && (cnt_q.n_inst != '0) && f_executed(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n || alloc_hit) begin
      valid    <= alloc_hit && rst_n;
      cnt_q    <= '0;
      crit_q   <= '0;
      cmem_q   <= '0;
      ord_mask <= '0;
      dat_mask <= '0;
    end else begin
      if (release_slot) valid <= 1'b0;
      cnt_q    <= cnt_d;
      crit_q   <= crit_d;
      cmem_q   <= crit_mem_nxt;
      ord_mask <= (ord_mask | ord_set) & ~clr_bits;
      dat_mask <= (dat_mask | dat_set) & ~clr_bits;
    end
  end

  assign waiting   = valid && f_waiting(cnt_q);
  assign pending   = valid && f_pending(cnt_q);
  assign ready     = valid && f_ready(cnt_q);
  assign executing = valid && f_executing(cnt_q);
  assign executed  = valid && f_executed(cnt_q);
  assign has_succ  = (ord_mask | dat_mask) != '0;
  assign crit      = valid ? crit_q : '0;
endmodule

// File: rtl/dg_tracker.sv
module dg_tracker #(
  parameter int NUM_SLOTS = 16,
  parameter int CYC_W     = 8,
  parameter int GID_W     = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_req,
  output logic [IDX_W-1:0]           alloc_slot,
  output logic [GID_W-1:0]           alloc_gid,
  output logic                       table_full,
  input  logic                       add_vld,
  input  logic [IDX_W-1:0]           add_slot,
  output logic                       add_err,
  input  logic                       edge_vld,
  input  logic [IDX_W-1:0]           edge_src,
  input  logic [IDX_W-1:0]           edge_dst,
  input  logic                       edge_data,
  input  logic                       issue_vld,
  input  logic [IDX_W-1:0]           issue_slot,
  input  logic [CYC_W-1:0]           issue_cyc,
  input  logic                       done_vld,
  input  logic [IDX_W-1:0]           done_slot,
  output logic [NUM_SLOTS-1:0]       grp_valid,
  output logic [NUM_SLOTS-1:0]       grp_waiting,
  output logic [NUM_SLOTS-1:0]       grp_pending,
  output logic [NUM_SLOTS-1:0]       grp_ready,
  output logic [NUM_SLOTS-1:0]       grp_executing,
  output logic [NUM_SLOTS-1:0]       grp_executed,
  output logic [NUM_SLOTS*CYC_W-1:0] crit_cycles
);
  logic [NUM_SLOTS-1:0] grant_1h, go_exec, go_done, has_succ;
  logic [NUM_SLOTS-1:0] ord_mask [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] dat_mask [NUM_SLOTS];
  logic [CYC_W-1:0]     cmem_nxt [NUM_SLOTS];
  logic [CYC_W-1:0]     crit_w   [NUM_SLOTS];

  // named internal events
  logic                 edge_ok, ord_keep, dat_keep, edge_start;
  logic                 add_ok, iss_ok, don_ok, iss_go, don_go;
  logic [NUM_SLOTS-1:0] dst_1h, new_ord, new_dat, iss_ord, iss_dat, don_dat;

  dg_slot_alloc #(.NUM_SLOTS(NUM_SLOTS), .GID_W(GID_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .slot_valid(grp_valid),
    .alloc_slot(alloc_slot), .alloc_gid(alloc_gid), .table_full(table_full),
    .grant_1h(grant_1h)
  );

  assign edge_ok = edge_vld && (edge_src != edge_dst) && grp_valid[edge_src]
                && grp_valid[edge_dst] && !grp_executed[edge_src];
  assign ord_keep   = edge_ok && !edge_data && !grp_executing[edge_src];
  assign dat_keep   = edge_ok && edge_data;
  assign edge_start = dat_keep && grp_executing[edge_src];
  assign dst_1h     = NUM_SLOTS'(1) << edge_dst;
  assign new_ord    = ord_keep ? dst_1h : '0;
  assign new_dat    = dat_keep ? dst_1h : '0;

  assign add_ok  = add_vld && grp_valid[add_slot] && !has_succ[add_slot];
  assign add_err = add_vld && grp_valid[add_slot] && has_succ[add_slot];
  assign iss_ok  = issue_vld && grp_valid[issue_slot];
  assign don_ok  = done_vld && grp_valid[done_slot];

  // credits fan out through the old masks plus any edge landing this cycle
  assign iss_go  = iss_ok && go_exec[issue_slot];
  assign don_go  = don_ok && go_done[done_slot];
  assign iss_ord = iss_go ? (ord_mask[issue_slot] | ((edge_src == issue_slot) ? new_ord : '0)) : '0;
  assign iss_dat = iss_go ? (dat_mask[issue_slot] | ((edge_src == issue_slot) ? new_dat : '0)) : '0;
  assign don_dat = don_go ? (dat_mask[done_slot] | ((edge_src == done_slot) ? new_dat : '0)) : '0;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic             edge_to, cand_vld;
    logic [1:0]       start_up, fin_up;
    logic [CYC_W-1:0] c_edge, c_iss, cand;

    assign edge_to  = edge_start && (edge_dst == IDX_W'(i));
    assign start_up = {1'b0, edge_to} + {1'b0, iss_dat[i]};
    assign fin_up   = {1'b0, iss_ord[i]} + {1'b0, don_dat[i]};
    assign c_edge   = edge_to ? cmem_nxt[edge_src] : '0;
    assign c_iss    = iss_dat[i] ? cmem_nxt[issue_slot] : '0;
    assign cand     = (c_edge > c_iss) ? c_edge : c_iss;
    assign cand_vld = edge_to || iss_dat[i];

    dg_group_slot #(.NUM_SLOTS(NUM_SLOTS), .CYC_W(CYC_W)) u_grp (
      .clk(clk), .rst_n(rst_n), .alloc_hit(grant_1h[i]), .clr_bits(grant_1h),
      .ord_set((edge_src == IDX_W'(i)) ? new_ord : '0),
      .dat_set((edge_src == IDX_W'(i)) ? new_dat : '0),
      .add_hit(add_ok && add_slot == IDX_W'(i)),
      .pred_hit((ord_keep || dat_keep) && edge_dst == IDX_W'(i)),
      .issue_hit(iss_ok && issue_slot == IDX_W'(i)), .issue_cyc(issue_cyc),
      .done_hit(don_ok && done_slot == IDX_W'(i)),
      .start_up(start_up), .start_dn(don_dat[i]), .fin_up(fin_up),
      .cand_vld(cand_vld), .cand_cyc(cand),
      .valid(grp_valid[i]), .waiting(grp_waiting[i]), .pending(grp_pending[i]),
      .ready(grp_ready[i]), .executing(grp_executing[i]), .executed(grp_executed[i]),
      .go_exec(go_exec[i]), .go_done(go_done[i]), .has_succ(has_succ[i]),
      .crit(crit_w[i]), .crit_mem_nxt(cmem_nxt[i]),
      .ord_mask(ord_mask[i]), .dat_mask(dat_mask[i])
    );

    assign crit_cycles[i*CYC_W +: CYC_W] = crit_w[i];
  end
endmodule

// File: rtl/dg_tracker_chk.sv
module dg_tracker_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int CYC_W     = 8,
  parameter int GID_W     = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       alloc_req,
  input logic [GID_W-1:0]           alloc_gid,
  input logic                       table_full,
  input logic                       add_vld,
  input logic                       add_err,
  input logic                       edge_vld,
  input logic                       issue_vld,
  input logic [NUM_SLOTS-1:0]       grp_waiting,
  input logic [NUM_SLOTS-1:0]       grp_pending,
  input logic [NUM_SLOTS-1:0]       grp_ready,
  input logic [NUM_SLOTS-1:0]       grp_executing,
  input logic [NUM_SLOTS-1:0]       grp_executed,
  input logic [NUM_SLOTS*CYC_W-1:0] crit_cycles
);
  p_wpr_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_waiting & grp_pending) | (grp_waiting & grp_ready) | (grp_pending & grp_ready)) == '0);

  p_exec_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_executing & grp_executed) == '0);

  p_gid_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gid != '0);

  p_full_holds_gid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && table_full) |=> alloc_gid == $past(alloc_gid));

  p_grant_steps_gid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !table_full) |=> alloc_gid != $past(alloc_gid));

  p_err_needs_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
    add_err |-> add_vld);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_crit
    p_crit_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_vld && !issue_vld) |=>
        crit_cycles[i*CYC_W +: CYC_W] <= $past(crit_cycles[i*CYC_W +: CYC_W]));
  end
endmodule

bind dg_tracker dg_tracker_chk #(.NUM_SLOTS(NUM_SLOTS), .CYC_W(CYC_W), .GID_W(GID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gid(alloc_gid),
  .table_full(table_full), .add_vld(add_vld), .add_err(add_err),
  .edge_vld(edge_vld), .issue_vld(issue_vld), .grp_waiting(grp_waiting),
  .grp_pending(grp_pending), .grp_ready(grp_ready), .grp_executing(grp_executing),
  .grp_executed(grp_executed), .crit_cycles(crit_cycles)
);

// File: tb/sim_dg_tracker.sv
module sim_dg_tracker;
  localparam int NS = 16;
  localparam int CW = 8;
  localparam int GW = 8;

  localparam int OP_ALLOC = 0, OP_ADD = 1, OP_EDGE_O = 2, OP_EDGE_D = 3,
                 OP_ISSUE = 4, OP_DONE = 5, OP_IDLE = 6;

  // expected status nibble order: {valid, waiting, pending, ready, executing, executed}
  typedef struct packed {
    logic [2:0] op;
    logic [3:0] a;
    logic [3:0] b;
    logic [7:0] cyc;
    logic [3:0] probe;
    logic [5:0] st;
    logic [7:0] crit;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'd0, 4'd0, 8'd0, 4'd0, 6'b100101, 8'd0},  // R1 R4 fresh group 0
    '{3'd0, 4'd0, 4'd0, 8'd0, 4'd1, 6'b100101, 8'd0},  // R2 next slot 1
    '{3'd1, 4'd0, 4'd0, 8'd0, 4'd0, 6'b100100, 8'd0},  // R4 member added
    '{3'd1, 4'd0, 4'd0, 8'd0, 4'd0, 6'b100100, 8'd0},
    '{3'd1, 4'd1, 4'd0, 8'd0, 4'd1, 6'b100100, 8'd0},
    '{3'd3, 4'd0, 4'd1, 8'd0, 4'd1, 6'b110000, 8'd0},  // R3 waiting
    '{3'd0, 4'd0, 4'd0, 8'd0, 4'd2, 6'b100101, 8'd0},
    '{3'd1, 4'd2, 4'd0, 8'd0, 4'd2, 6'b100100, 8'd0},
    '{3'd2, 4'd0, 4'd2, 8'd0, 4'd2, 6'b110000, 8'd0},
    '{3'd4, 4'd0, 4'd0, 8'd5, 4'd0, 6'b100100, 8'd0},  // R4 half issued
    '{3'd4, 4'd0, 4'd0, 8'd9, 4'd1, 6'b101000, 8'd9},  // R5 R9 data succ pending
    '{3'd6, 4'd0, 4'd0, 8'd0, 4'd2, 6'b100100, 8'd0},  // R5 order succ ready
    '{3'd6, 4'd0, 4'd0, 8'd0, 4'd0, 6'b100110, 8'd0},  // R4 executing
    '{3'd5, 4'd0, 4'd0, 8'd0, 4'd0, 6'b100110, 8'd0},
    '{3'd5, 4'd0, 4'd0, 8'd0, 4'd1, 6'b100100, 8'd9},  // R6 data succ ready
    '{3'd6, 4'd0, 4'd0, 8'd0, 4'd0, 6'b000000, 8'd0},  // R10 slot released
    '{3'd0, 4'd0, 4'd0, 8'd0, 4'd0, 6'b100101, 8'd0}   // R10 slot reused
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           alloc_req = 1'b0;
  logic [3:0]     alloc_slot;
  logic [GW-1:0]  alloc_gid;
  logic           table_full;
  logic           add_vld = 1'b0;
  logic [3:0]     add_slot = '0;
  logic           add_err;
  logic           edge_vld = 1'b0;
  logic [3:0]     edge_src = '0;
  logic [3:0]     edge_dst = '0;
  logic           edge_data = 1'b0;
  logic           issue_vld = 1'b0;
  logic [3:0]     issue_slot = '0;
  logic [CW-1:0]  issue_cyc = '0;
  logic           done_vld = 1'b0;
  logic [3:0]     done_slot = '0;
  logic [NS-1:0]  grp_valid, grp_waiting, grp_pending, grp_ready, grp_executing, grp_executed;
  logic [NS*CW-1:0] crit_cycles;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dg_tracker #(.NUM_SLOTS(NS), .CYC_W(CW), .GID_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_slot(alloc_slot),
    .alloc_gid(alloc_gid), .table_full(table_full), .add_vld(add_vld),
    .add_slot(add_slot), .add_err(add_err), .edge_vld(edge_vld),
    .edge_src(edge_src), .edge_dst(edge_dst), .edge_data(edge_data),
    .issue_vld(issue_vld), .issue_slot(issue_slot), .issue_cyc(issue_cyc),
    .done_vld(done_vld), .done_slot(done_slot), .grp_valid(grp_valid),
    .grp_waiting(grp_waiting), .grp_pending(grp_pending), .grp_ready(grp_ready),
    .grp_executing(grp_executing), .grp_executed(grp_executed),
    .crit_cycles(crit_cycles)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int st(int p);
    return int'({grp_valid[p], grp_waiting[p], grp_pending[p],
                 grp_ready[p], grp_executing[p], grp_executed[p]});
  endfunction

  function automatic int crit(int p);
    return int'(crit_cycles[p*CW +: CW]);
  endfunction

  // drive at a falling edge, hold for one rising edge, release at the next falling edge
  task automatic do_op(int op, int a, int b, int cyc);
    case (op)
      OP_ALLOC:  alloc_req = 1'b1;
      OP_ADD:    begin add_vld = 1'b1; add_slot = 4'(a); end
      OP_EDGE_O: begin edge_vld = 1'b1; edge_src = 4'(a); edge_dst = 4'(b); edge_data = 1'b0; end
      OP_EDGE_D: begin edge_vld = 1'b1; edge_src = 4'(a); edge_dst = 4'(b); edge_data = 1'b1; end
      OP_ISSUE:  begin issue_vld = 1'b1; issue_slot = 4'(a); issue_cyc = CW'(cyc); end
      OP_DONE:   begin done_vld = 1'b1; done_slot = 4'(a); end
      default: ;
    endcase
    @(negedge clk);
    alloc_req = 1'b0; add_vld = 1'b0; edge_vld = 1'b0; issue_vld = 1'b0; done_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 valid", int'(grp_valid), 0);
    chk("R1 alloc_slot", int'(alloc_slot), 0);
    chk("R1 alloc_gid", int'(alloc_gid), 1);
    chk("R1 table_full", int'(table_full), 0);

    for (int k = 0; k < NV; k++) begin
      do_op(int'(VECS[k].op), int'(VECS[k].a), int'(VECS[k].b), int'(VECS[k].cyc));
      chk($sformatf("R3/R4 table row %0d status", k), st(int'(VECS[k].probe)), int'(VECS[k].st));
      chk($sformatf("R9 table row %0d crit", k), crit(int'(VECS[k].probe)), int'(VECS[k].crit));
    end
    chk("R2 gid after reuse", int'(alloc_gid), 5);

    // directed: executing source, dropped order edge, critical countdown, rejected add
    do_reset();
    for (int k = 0; k < 4; k++) do_op(OP_ALLOC, 0, 0, 0);
    do_op(OP_ADD, 0, 0, 0);
    do_op(OP_ADD, 1, 0, 0);
    do_op(OP_ADD, 2, 0, 0);
    do_op(OP_ADD, 3, 0, 0);
    do_op(OP_ISSUE, 0, 0, 7);
    chk("R4 A executing", st(0), 6'b100110);
    do_op(OP_EDGE_O, 0, 1, 0);
    chk("R7 order edge dropped", st(1), 6'b100100);
    do_op(OP_EDGE_D, 0, 1, 0);
    chk("R7 data edge starts at once", st(1), 6'b101000);
    chk("R9 crit from source member", crit(1), 7);
    do_op(OP_EDGE_O, 3, 2, 0);
    chk("R3 C waiting", st(2), 6'b110000);
    do_op(OP_EDGE_D, 0, 2, 0);
    chk("R9 C crit loaded", crit(2), 7);
    repeat (3) @(negedge clk);
    chk("R9 C crit counts down", crit(2), 4);
    chk("R9 B crit frozen while pending", crit(1), 7);
    add_vld = 1'b1; add_slot = 4'd0;
    #1;
    chk("R8 add_err raised", int'(add_err), 1);
    @(negedge clk);
    add_vld = 1'b0;
    chk("R8 add ignored A still executing", st(0), 6'b100110);
    do_op(OP_DONE, 0, 0, 0);
    chk("R6 B ready", st(1), 6'b100100);
    chk("R6 C still waiting", st(2), 6'b110000);
    chk("R9 C crit", crit(2), 2);
    do_op(OP_ISSUE, 3, 0, 2);
    chk("R5 order credit makes C ready", st(2), 6'b100100);
    chk("R9 C crit after last dec", crit(2), 1);
    @(negedge clk);
    chk("R9 no dec when not waiting", crit(2), 1);
    do_op(OP_EDGE_D, 1, 1, 0);
    chk("R11 self edge ignored", st(1), 6'b100100);
    chk("R10 freed slot offered", int'(alloc_slot), 0);
    do_op(OP_ALLOC, 0, 0, 0);
    do_op(OP_EDGE_D, 0, 1, 0);
    chk("R11 edge from empty group ignored", st(1), 6'b100100);

    // directed: fill the table
    do_reset();
    for (int k = 0; k < NS; k++) begin
      chk("R2 lowest free slot", int'(alloc_slot), k);
      chk("R2 gid sequence", int'(alloc_gid), k + 1);
      do_op(OP_ALLOC, 0, 0, 0);
    end
    chk("R2 table_full", int'(table_full), 1);
    do_op(OP_ALLOC, 0, 0, 0);
    chk("R2 gid held when full", int'(alloc_gid), NS + 1);
    chk("R2 all slots valid", int'(grp_valid), 16'hffff);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule